// File: doc/BRIEF.md
# Key-Locked DRAM Controller Configuration Register Bank

This block holds the software-visible configuration words of a DRAM controller behind a simple memory-mapped request bus with a 4 KB window. Word 0 is a protection key register. A write to any other word is dropped unless word 0 currently holds the unlock value `0xFC600309`. A dropped write raises a one-cycle error pulse. The `locked` output tells the rest of the chip whether the bank is open for writes.

Word 1 is the configuration word, and its contents are exported on `cfg_word` to the controller's engines. Each silicon variant, chosen by a parameter, protects its own set of read-only bit positions in this word, which keep their value across writes. The reset value of word 1 encodes the installed memory size, which is given in megabytes as a parameter. An unsupported size falls back to a default code. Every request is answered one cycle later with `rsp_ready`. Read data and an error flag travel with that answer.

Top module: `memctl_cfg_regs`

## Requirements
- R1: After reset every word reads zero except word 1, and `locked` is high.
- R2: Word 0 (byte address 0x000) is writable at all times and reads back the last value written.
- R3: While word 0 differs from 0xFC600309, a write to any other in-range word leaves it unchanged and gives `rsp_err` high in the response.
- R4: `locked` is high exactly when word 0 differs from 0xFC600309, and it follows a write to word 0 in the response cycle.
- R5: With VARIANT=0, a write to word 1 (byte 0x004) keeps the bits in mask 0xFFFFF84C and takes all other bits from the write data.
- R6: With VARIANT=1, a write to word 1 keeps the bits in mask 0xF00FC04C and takes all other bits from the write data.
- R7: The reset value of word 1 is 0x40 | code with VARIANT=0, and 0x1000000C | code with VARIANT=1, where code is the size code in bits 1:0.
- R8: With VARIANT=0, MEM_MB values 64/128/256/512 give codes 0/1/2/3. With VARIANT=1, 128/256/512/1024 give codes 0/1/2/3. Any other size gives code 2.
- R9: Each request (`req_valid` high for one cycle) gives `rsp_ready` high in the next cycle only. `rsp_rdata` carries the addressed word for an in-range aligned read and zero otherwise.
- R10: An access whose word index (address bits 11:2) is at least NUM_REGS, or whose address bits 1:0 are nonzero, changes no word, reads zero and gives `rsp_err` high.
- R11: `rsp_err` is high only in a response cycle, and it is high for one cycle per faulty request.
- R12: `cfg_word` always equals the current contents of word 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Request was dropped or out of range |
| rsp_rdata | output | 32 | Read data, valid with rsp_ready |
| locked | output | 1 | Word 0 differs from the unlock key |
| cfg_word | output | 32 | Current configuration word |

## Verification
The bench drives one bus into two instances: variant 0 with a supported 512 MB size, and variant 1 with an unsupported 1000 MB size, so that the normal size code and the fallback code are both seen. Writes are issued while locked, with a near-miss key and with the true key. Comparing these three cases separates gating on the exact key from gating on the mere presence of a write to word 0. Writing all-ones and then all-zeros to word 1 separates a merge that keeps the read-only bits from one that clears or forces them. Accesses to index 64, to misaligned addresses and to the last word test whether the window is truncated, which would alias writes onto the key word, and catch an off-by-one in the range test. A run of back-to-back requests and a reset in mid-run test the response timing and the restored defaults.

// File: rtl/memctl_cfg_pkg.sv
package memctl_cfg_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam logic [31:0] UNLOCK_KEY = 32'hFC60_0309;
    localparam int unsigned KEY_IDX    = 0;
    localparam int unsigned CFG_IDX    = 1;

    // read-only bit positions of the configuration word per variant
    localparam logic [31:0] RO_MASK_V0 = 32'hFFFF_F84C;
    localparam logic [31:0] RO_MASK_V1 = 32'hF00F_C04C;

    typedef struct packed {
        logic        ready;
        logic        err;
        logic [31:0] rdata;
    } rsp_t;

    function automatic logic [1:0] size_code(int unsigned variant, int unsigned mb);
        logic [1:0] code;
        code = 2'd2;
        if (variant == 0) begin
            case (mb)
                64:      code = 2'd0;
                128:     code = 2'd1;
                256:     code = 2'd2;
                512:     code = 2'd3;
                default: code = 2'd2;
            endcase
        end else begin
            case (mb)
                128:     code = 2'd0;
                256:     code = 2'd1;
                512:     code = 2'd2;
                1024:    code = 2'd3;
                default: code = 2'd2;
            endcase
        end
        return code;
    endfunction

    function automatic logic [31:0] ro_mask(int unsigned variant);
        return (variant == 0) ? RO_MASK_V0 : RO_MASK_V1;
    endfunction

    function automatic logic [31:0] cfg_reset(int unsigned variant, int unsigned mb);
        logic [31:0] base;
        base = (variant == 0) ? 32'h0000_0040 : 32'h1000_000C;
        return base | {30'd0, size_code(variant, mb)};
    endfunction

endpackage

// File: rtl/memctl_cfg_decode.sv
module memctl_cfg_decode #(
    parameter int unsigned NUM_REGS = 64,
    parameter int unsigned ADDR_W   = 12,
    localparam int unsigned WIN_W   = ADDR_W - 2,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              hit,
    output logic              is_key
);
    localparam logic [WIN_W-1:0] LAST_IDX = WIN_W'(NUM_REGS - 1);

    logic [WIN_W-1:0] win_idx;
    logic             aligned;
    logic             in_range;

    always_comb begin
        win_idx  = addr[ADDR_W-1:2];
        aligned  = (addr[1:0] == 2'b00);
        in_range = (win_idx <= LAST_IDX);
        hit      = aligned && in_range;
        idx      = win_idx[IDX_W-1:0];
        is_key   = hit && (win_idx == '0);
    end

endmodule

// File: rtl/memctl_cfg_keygate.sv
module memctl_cfg_keygate
    import memctl_cfg_pkg::*;
(
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        hit,
    input  logic        is_key,
    input  logic [31:0] key_word,
    output logic        locked,
    output logic        wr_allow,
    output logic        wr_drop
);
    logic wr_try;

    always_comb begin
        locked   = (key_word != UNLOCK_KEY);
        wr_try   = req_valid && req_write && hit;
        wr_allow = wr_try && (is_key || !locked);
        wr_drop  = wr_try && !is_key && locked;
    end

endmodule

// File: rtl/memctl_cfg_bank.sv
module memctl_cfg_bank
    import memctl_cfg_pkg::*;
#(
    parameter int unsigned NUM_REGS = 64,
    parameter int unsigned VARIANT  = 0,
    parameter int unsigned MEM_MB   = 256,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_word,
    output logic [31:0]      key_word,
    output logic [31:0]      cfg_word
);
    localparam logic [31:0] RO_BITS = ro_mask(VARIANT);
    localparam logic [31:0] CFG_RST = cfg_reset(VARIANT, MEM_MB);

    logic [NUM_REGS-1:0][31:0] regs_d;
    logic [NUM_REGS-1:0][31:0] regs_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(g));

        if (g == CFG_IDX) begin : g_cfg
            always_comb begin
                regs_d[g] = regs_q[g];
                if (sel) begin
                    regs_d[g] = (regs_q[g] & RO_BITS) | (wr_data & ~RO_BITS);
                end
            end
            always_ff @(posedge clk) begin
                if (!rst_n) regs_q[g] <= CFG_RST;
                else        regs_q[g] <= regs_d[g];
            end
        end else begin : g_plain
            always_comb begin
                regs_d[g] = regs_q[g];
                if (sel) begin
                    regs_d[g] = wr_data;
                end
            end
            always_ff @(posedge clk) begin
                if (!rst_n) regs_q[g] <= '0;
                else        regs_q[g] <= regs_d[g];
            end
        end
    end

    always_comb begin
        rd_word  = regs_q[rd_idx];
        key_word = regs_q[KEY_IDX];
        cfg_word = regs_q[CFG_IDX];
    end

endmodule

// File: rtl/memctl_cfg_regs.sv
module memctl_cfg_regs
    import memctl_cfg_pkg::*;
#(
    parameter int unsigned VARIANT  = 0,
    parameter int unsigned MEM_MB   = 256,
    parameter int unsigned NUM_REGS = 64,
    parameter int unsigned ADDR_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_ready,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              locked,
    output logic [31:0]       cfg_word
);
    localparam int unsigned IDX_W = $clog2(NUM_REGS);

    logic [IDX_W-1:0] idx;
    logic             hit;
    logic             is_key;
    logic             wr_allow;
    logic             wr_drop;
    logic [31:0]      rd_word;
    logic [31:0]      key_word;

    rsp_t rsp_d;
    rsp_t rsp_q;

    memctl_cfg_decode #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) u_decode (
        .addr   (req_addr),
        .idx    (idx),
        .hit    (hit),
        .is_key (is_key)
    );

    memctl_cfg_keygate u_keygate (
        .req_valid (req_valid),
        .req_write (req_write),
        .hit       (hit),
        .is_key    (is_key),
        .key_word  (key_word),
        .locked    (locked),
        .wr_allow  (wr_allow),
        .wr_drop   (wr_drop)
    );

    memctl_cfg_bank #(
        .NUM_REGS (NUM_REGS),
        .VARIANT  (VARIANT),
        .MEM_MB   (MEM_MB)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_allow),
        .wr_idx   (idx),
        .wr_data  (req_wdata),
        .rd_idx   (idx),
        .rd_word  (rd_word),
        .key_word (key_word),
        .cfg_word (cfg_word)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.ready = req_valid;
        rsp_d.err   = req_valid && (!hit || wr_drop);
        if (req_valid && !req_write && hit) begin
            rsp_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_ready = rsp_q.ready;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;

endmodule

// File: rtl/memctl_cfg_regs_chk.sv
module memctl_cfg_regs_chk
    import memctl_cfg_pkg::*;
#(
    parameter int unsigned VARIANT  = 0,
    parameter int unsigned NUM_REGS = 64,
    parameter int unsigned ADDR_W   = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_ready,
    input logic              rsp_err,
    input logic [31:0]       rsp_rdata,
    input logic              locked,
    input logic [31:0]       cfg_word
);
    localparam int unsigned WIN_W   = ADDR_W - 2;
    localparam logic [31:0] RO_BITS = ro_mask(VARIANT);
    localparam logic [WIN_W-1:0] LAST_IDX = WIN_W'(NUM_REGS - 1);

    logic [WIN_W-1:0] w_idx;
    logic             good;

    assign w_idx = req_addr[ADDR_W-1:2];
    assign good  = (req_addr[1:0] == 2'b00) && (w_idx <= LAST_IDX);

    // R9
    ready_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_ready);

    // R9
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_ready && !rsp_err));

    // R10
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !good) |=> (rsp_err && rsp_rdata == 32'd0));

    // R3
    locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && good && w_idx != '0 && locked)
        |=> (rsp_err && locked && $stable(cfg_word)));

    // R4
    key_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && good && w_idx == '0 && req_wdata == UNLOCK_KEY)
        |=> !locked);

    // R4
    key_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && good && w_idx == '0 && req_wdata != UNLOCK_KEY)
        |=> locked);

    // R5 R6
    cfg_ro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && good && w_idx == WIN_W'(CFG_IDX))
        |=> ((cfg_word & RO_BITS) == $past(cfg_word & RO_BITS)));

    // R11
    err_in_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_ready);

endmodule

bind memctl_cfg_regs memctl_cfg_regs_chk #(
    .VARIANT  (VARIANT),
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_ready (rsp_ready),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .locked    (locked),
    .cfg_word  (cfg_word)
);

// File: tb/memctl_cfg_regs_tb.sv
module memctl_cfg_regs_tb;

    localparam logic [31:0] KEY = 32'hFC60_0309;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;

    logic        rdy [2];
    logic        err [2];
    logic [31:0] rdat [2];
    logic        lck [2];
    logic [31:0] cfg [2];

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // reference state, one word array per instance
    logic [31:0] mdl [2][64];
    logic        e_rdy [2];
    logic        e_err [2];
    logic [31:0] e_rdat [2];
    logic [31:0] ro [2];
    logic [31:0] rstv [2];

    always #10 clk = ~clk;

    memctl_cfg_regs #(.VARIANT(0), .MEM_MB(512), .NUM_REGS(64), .ADDR_W(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rdy[0]), .rsp_err(err[0]),
        .rsp_rdata(rdat[0]), .locked(lck[0]), .cfg_word(cfg[0]));

    memctl_cfg_regs #(.VARIANT(1), .MEM_MB(1000), .NUM_REGS(64), .ADDR_W(12)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rdy[1]), .rsp_err(err[1]),
        .rsp_rdata(rdat[1]), .locked(lck[1]), .cfg_word(cfg[1]));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int v = 0; v < 2; v++) begin
            for (int i = 0; i < 64; i++) mdl[v][i] = 32'd0;
            mdl[v][1] = rstv[v];
            e_rdy[v] = 1'b0; e_err[v] = 1'b0; e_rdat[v] = 32'd0;
        end
    endtask

    task automatic compare_all();
        for (int v = 0; v < 2; v++) begin
            chk($sformatf("R9 ready v%0d", v), {31'd0, rdy[v]}, {31'd0, e_rdy[v]});
            chk($sformatf("R3/R10/R11 err v%0d", v), {31'd0, err[v]}, {31'd0, e_err[v]});
            chk($sformatf("R9 rdata v%0d", v), rdat[v], e_rdat[v]);
            chk($sformatf("R4 locked v%0d", v), {31'd0, lck[v]}, {31'd0, mdl[v][0] != KEY});
            chk($sformatf("R12 cfg v%0d", v), cfg[v], mdl[v][1]);
        end
    endtask

    task automatic step(input logic v_i, input logic w_i, input logic [11:0] a, input logic [31:0] d);
        int idx;
        bit ok;
        req_valid = v_i; req_write = w_i; req_addr = a; req_wdata = d;
        idx = int'(a >> 2);
        ok  = (a[1:0] == 2'b00) && (idx < 64);
        for (int v = 0; v < 2; v++) begin
            e_rdy[v]  = v_i;
            e_err[v]  = v_i && (!ok || (w_i && idx != 0 && mdl[v][0] != KEY));
            e_rdat[v] = (v_i && !w_i && ok) ? mdl[v][idx] : 32'd0;
            if (v_i && w_i && ok && (idx == 0 || mdl[v][0] == KEY)) begin
                if (idx == 1) mdl[v][1] = (mdl[v][1] & ro[v]) | (d & ~ro[v]);
                else          mdl[v][idx] = d;
            end
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 1'b0, 12'h000, 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        ro[0] = 32'hFFFF_F84C; ro[1] = 32'hF00F_C04C;
        rstv[0] = 32'h0000_0043;   // R7 R8: bit 6, 512 MB -> code 3
        rstv[1] = 32'h1000_000E;   // R7 R8: version 1, aperture 3, 1000 MB -> fallback 2
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_all();                                   // R1 idle state
        chk("R1 locked after reset", {31'd0, lck[0]}, 32'd1);

        step(1, 0, 12'h004, 0);                          // R7 R8 reset config
        chk("R7 R8 cfg reset v0", rdat[0], 32'h0000_0043);
        chk("R7 R8 cfg reset v1", rdat[1], 32'h1000_000E);
        step(1, 0, 12'h000, 0);
        chk("R1 key reads zero", rdat[0], 32'd0);
        step(1, 0, 12'h0FC, 0);
        chk("R1 last word zero", rdat[1], 32'd0);

        step(1, 1, 12'h008, 32'h0000_1234);              // R3 locked write
        chk("R3 dropped err", {31'd0, err[0]}, 32'd1);
        step(1, 0, 12'h008, 0);
        chk("R3 word unchanged", rdat[0], 32'd0);
        step(1, 1, 12'h004, 32'hFFFF_FFFF);
        chk("R3 cfg unchanged", cfg[1], 32'h1000_000E);

        step(1, 1, 12'h000, 32'hFC60_0308);              // R2 R4 near-miss key
        chk("R4 near key locked", {31'd0, lck[0]}, 32'd1);
        step(1, 0, 12'h000, 0);
        chk("R2 key readback", rdat[0], 32'hFC60_0308);
        step(1, 1, 12'h008, 32'h5555_0000);
        step(1, 1, 12'h000, KEY);
        chk("R4 unlocked", {31'd0, lck[1]}, 32'd0);

        step(1, 1, 12'h008, 32'hA5A5_5A5A);
        step(1, 0, 12'h008, 0);
        chk("R3 open write readback", rdat[0], 32'hA5A5_5A5A);

        step(1, 1, 12'h004, 32'hFFFF_FFFF);              // R5 R6 merge
        chk("R5 cfg ones v0", cfg[0], 32'h0000_07F3);
        chk("R6 cfg ones v1", cfg[1], 32'h1FF0_3FBF);
        step(1, 1, 12'h004, 32'h0000_0000);
        chk("R5 cfg zeros v0", cfg[0], 32'h0000_0040);
        chk("R6 cfg zeros v1", cfg[1], 32'h1000_000C);
        step(1, 1, 12'h004, 32'h0123_4567);

        step(1, 1, 12'h0FC, 32'hDEAD_BEEF);              // last word
        step(1, 0, 12'h0FC, 0);
        chk("R10 last word in range", rdat[1], 32'hDEAD_BEEF);

        step(1, 0, 12'h100, 0);                          // R10 index 64
        chk("R10 oor read err", {31'd0, err[0]}, 32'd1);
        step(1, 1, 12'h100, 32'd0);
        idle(1);
        chk("R10 oor write no alias", {31'd0, lck[0]}, 32'd0);
        step(1, 1, 12'hFFC, 32'h1111_1111);
        step(1, 1, 12'h00A, 32'h2222_2222);              // misaligned
        step(1, 0, 12'h008, 0);
        chk("R10 misaligned ignored", rdat[0], 32'hA5A5_5A5A);
        step(1, 0, 12'h005, 0);
        chk("R10 misaligned read", rdat[1], 32'd0);

        for (int i = 0; i < 8; i++) step(1, 1, 12'(16 + 4 * i), 32'h100 + i);
        for (int i = 0; i < 8; i++) step(1, 0, 12'(16 + 4 * i), 0);
        idle(2);
        chk("R9 idle no ready", {31'd0, rdy[0]}, 32'd0);

        step(1, 1, 12'h000, 32'd0);                      // relock
        step(1, 1, 12'h008, 32'h7777_7777);
        chk("R11 single err", {31'd0, err[1]}, 32'd1);
        idle(1);
        chk("R11 err clears", {31'd0, err[1]}, 32'd0);
        step(1, 0, 12'h008, 0);

        rst_n = 1'b0;                                    // R1 mid-run reset
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        compare_all();
        step(1, 0, 12'h008, 0);
        chk("R1 word cleared", rdat[0], 32'd0);
        idle(2);
        finish_run();
    end

endmodule